// File: doc/BRIEF.md
# Seven-Segment Travelling Dash Animator

This block animates a single lit segment around a row of multiplexed seven-segment digits. The dash starts on the upper segment of the rightmost digit and moves leftward across the upper segments, one digit per step. At the leftmost digit it drops to the lower segment and travels back toward the right. After the lower segment of the rightmost digit it returns to the start, and the loop repeats for as long as steps arrive.

The speed is set outside the block. A one-cycle step strobe from an external prescaler moves the dash one place. Between strobes the dash stays where it is. The outputs are the active-low digit enable bus and the active-low segment bus, ready to drive the display pins directly. Only one digit is enabled at any time, so no further multiplexing is needed.

Top module: `seg_dash_anim`

## Requirements
- R1: While reset is high and on the first cycle after it, the dash is on the upper segment of digit 0. With four digits, digit_n reads 4'b1110 and seg_n reads 7'b0111111.
- R2: The dash moves one place on each clock edge where step is high. On any edge where step is low, both output buses keep their values.
- R3: The upper pass visits digit 0, then 1, then 2, then 3. Digit d enabled means digit_n bit d is 0 and every other bit is 1.
- R4: After the upper segment of digit 3, the next step moves the dash to the lower segment of digit 3. Further steps visit the lower segments of digits 2, 1 and 0 in that order.
- R5: A step taken from the lower segment of digit 0 puts the dash back on the upper segment of digit 0. The cycle is eight positions long.
- R6: Outside reset, exactly one bit of digit_n is 0 at every cycle.
- R7: seg_n is 7'b0111111 (bit 6, upper segment, low) during the upper pass and 7'b1110111 (bit 3, lower segment, low) during the lower pass. No other value appears.
- R8: If step stays high for k consecutive edges, the dash moves k places, one per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Advance strobe, one place per high edge |
| digit_n | output | 4 | Digit enables, active low, bit d is digit d (digit 0 rightmost) |
| seg_n | output | 7 | Segment drives, active low, bit 6 upper, bit 3 lower |

## Verification
The assertions assume that step is a clean synchronous level sampled at each edge. They also assume reset is held for at least one edge before any property is judged. Strobes that arrive during reset are taken to be discarded. The bench therefore changes step and rst only on falling edges and pulses reset for two edges. It only sends strobes once reset has been released. Its stimulus includes single strobes, idle gaps and strobes held high over several edges, which covers every adjacent-position step that the movement properties check.

// File: rtl/dash_pkg.sv
package dash_pkg;

   typedef enum logic {
      PASS_UPPER = 1'b0,
      PASS_LOWER = 1'b1
   } dash_pass_e;

   // number of bits needed to index the 2*n positions of the loop
   function automatic int pos_bits(input int n);
      return (2 * n <= 2) ? 1 : $clog2(2 * n);
   endfunction

endpackage

// File: rtl/dash_step_ctr.sv
module dash_step_ctr #(
   parameter int NUM_DIGITS = 4,
   parameter int POS_W      = dash_pkg::pos_bits(NUM_DIGITS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step,
   output logic [POS_W-1:0] pos
);
   localparam int               NUM_POS  = 2 * NUM_DIGITS;
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(NUM_POS - 1);

   if ((1 << POS_W) < NUM_POS) begin : g_bad_width
      $error("dash_step_ctr: POS_W too narrow for the position count");
   end

   logic [POS_W-1:0] pos_nxt;

   always_comb begin
      pos_nxt = pos;
      if (step) begin
         if (pos == LAST_POS) pos_nxt = '0;
         else                 pos_nxt = pos + POS_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) pos <= '0;
      else     pos <= pos_nxt;
   end

   // R2: no strobe, no movement
   assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(pos));

   // R2: a strobe moves one place forward
   assert_advance_R2: assert property (@(posedge clk) disable iff (rst)
      (step && pos != LAST_POS) |=> (pos == $past(pos) + POS_W'(1)));

   // R5: loop closes after the last position
   assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
      (step && pos == LAST_POS) |=> (pos == '0));

   assert_range_R5: assert property (@(posedge clk) disable iff (rst)
      pos <= LAST_POS);

endmodule

// File: rtl/dash_pos_decode.sv
module dash_pos_decode
   import dash_pkg::*;
#(
   parameter int NUM_DIGITS = 4,
   parameter int POS_W      = dash_pkg::pos_bits(NUM_DIGITS)
) (
   input  logic [POS_W-1:0]      pos,
   output logic [NUM_DIGITS-1:0] digit_n,
   output dash_pass_e            pass
);
   localparam int NUM_POS = 2 * NUM_DIGITS;

   assign pass = (pos >= POS_W'(NUM_DIGITS)) ? PASS_LOWER : PASS_UPPER;

   for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_dig
      // upper pass walks digits upward, lower pass walks them back down
      localparam logic [POS_W-1:0] UP_POS = POS_W'(d);
      localparam logic [POS_W-1:0] LO_POS = POS_W'(NUM_POS - 1 - d);
      assign digit_n[d] = !((pos == UP_POS) || (pos == LO_POS));
   end

endmodule

// File: rtl/seg_dash_anim.sv
module seg_dash_anim
   import dash_pkg::*;
#(
   parameter int NUM_DIGITS = 4,
   parameter int SEG_W      = 7,
   parameter int UPPER_BIT  = 6,
   parameter int LOWER_BIT  = 3
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  step,
   output logic [NUM_DIGITS-1:0] digit_n,
   output logic [SEG_W-1:0]      seg_n
);
   localparam int POS_W = pos_bits(NUM_DIGITS);
   localparam logic [SEG_W-1:0] UPPER_CODE = ~(SEG_W'(1) << UPPER_BIT);
   localparam logic [SEG_W-1:0] LOWER_CODE = ~(SEG_W'(1) << LOWER_BIT);

   if (NUM_DIGITS < 2) begin : g_bad_digits
      $error("seg_dash_anim: at least two digits required");
   end
   if (UPPER_BIT >= SEG_W || LOWER_BIT >= SEG_W) begin : g_bad_bits
      $error("seg_dash_anim: segment bit outside the bus");
   end
   if (UPPER_BIT == LOWER_BIT) begin : g_same_bits
      $error("seg_dash_anim: upper and lower segment bits must differ");
   end

   logic [POS_W-1:0] pos;
   dash_pass_e       pass;

   dash_step_ctr #(.NUM_DIGITS(NUM_DIGITS), .POS_W(POS_W)) u_ctr (
      .clk  (clk),
      .rst  (rst),
      .step (step),
      .pos  (pos)
   );

   dash_pos_decode #(.NUM_DIGITS(NUM_DIGITS), .POS_W(POS_W)) u_dec (
      .pos     (pos),
      .digit_n (digit_n),
      .pass    (pass)
   );

   for (genvar b = 0; b < SEG_W; b++) begin : g_seg
      if (b == UPPER_BIT) begin : g_up
         assign seg_n[b] = (pass != PASS_UPPER);
      end else if (b == LOWER_BIT) begin : g_lo
         assign seg_n[b] = (pass != PASS_LOWER);
      end else begin : g_off
         assign seg_n[b] = 1'b1;
      end
   end

   // R6: exactly one digit enabled
   assert_one_digit_R6: assert property (@(posedge clk) disable iff (rst)
      $countones(~digit_n) == 1);

   // R7: only the two legal segment codes
   assert_seg_code_R7: assert property (@(posedge clk) disable iff (rst)
      (seg_n == UPPER_CODE) || (seg_n == LOWER_CODE));

   // R3: upper pass steps one digit left
   assert_upper_walk_R3: assert property (@(posedge clk) disable iff (rst)
      (step && seg_n == UPPER_CODE && digit_n[NUM_DIGITS-1])
      |=> (seg_n == UPPER_CODE) &&
          (digit_n == {$past(digit_n[NUM_DIGITS-2:0]), 1'b1}));

   // R4: turn at the left end, then walk right on the lower segments
   assert_turn_R4: assert property (@(posedge clk) disable iff (rst)
      (step && seg_n == UPPER_CODE && !digit_n[NUM_DIGITS-1])
      |=> (seg_n == LOWER_CODE) && $stable(digit_n));

   assert_lower_walk_R4: assert property (@(posedge clk) disable iff (rst)
      (step && seg_n == LOWER_CODE && digit_n[0])
      |=> (seg_n == LOWER_CODE) &&
          (digit_n == {1'b1, $past(digit_n[NUM_DIGITS-1:1])}));

   // R5: lower segment of digit 0 returns to the start
   assert_loop_R5: assert property (@(posedge clk) disable iff (rst)
      (step && seg_n == LOWER_CODE && !digit_n[0])
      |=> (seg_n == UPPER_CODE) && $stable(digit_n));

endmodule

// File: tb/sim_seg_dash_anim.sv
module sim_seg_dash_anim;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       step = 1'b0;
   logic [3:0] digit_n;
   logic [6:0] seg_n;

   int total = 0;
   int bad   = 0;
   int epos  = 0;   // expected position 0..7

   always #10 clk = ~clk;

   seg_dash_anim u0 (
      .clk     (clk),
      .rst     (rst),
      .step    (step),
      .digit_n (digit_n),
      .seg_n   (seg_n)
   );

   function automatic logic [3:0] exp_dig(input int p);
      int d;
      d = (p < 4) ? p : 7 - p;
      return ~(4'b0001 << d);
   endfunction

   function automatic logic [6:0] exp_seg(input int p);
      return (p < 4) ? 7'b0111111 : 7'b1110111;
   endfunction

   task automatic check(input string tag);
      total++;
      if (digit_n !== exp_dig(epos) || seg_n !== exp_seg(epos)) begin
         bad++;
         $display("FAIL %s pos=%0d digit_n=%b seg_n=%b expected digit_n=%b seg_n=%b",
                  tag, epos, digit_n, seg_n, exp_dig(epos), exp_seg(epos));
      end
      total++;
      if ($countones(~digit_n) != 1) begin
         bad++;
         $display("FAIL R6 enabled digits=%0d expected 1", $countones(~digit_n));
      end
   endtask

   task automatic pulse_step();
      @(negedge clk) step = 1'b1;
      @(negedge clk) step = 1'b0;
      epos = (epos + 1) % 8;
   endtask

   task automatic t_reset();
      @(negedge clk) rst = 1'b1;
      step = 1'b0;
      @(negedge clk);
      @(negedge clk);
      epos = 0;
      check("R1 during reset");
      rst = 1'b0;
      @(negedge clk);
      check("R1 after reset");
   endtask

   task automatic t_hold();
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check("R2 hold without step");
      end
      pulse_step();
      check("R2 single step");
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R2 hold after step");
      end
   endtask

   task automatic t_upper();
      while (epos != 0) pulse_step();
      check("R3 start");
      for (int i = 0; i < 3; i++) begin
         pulse_step();
         check("R3 upper pass");
         check("R7 upper code");
      end
   endtask

   task automatic t_lower();
      for (int i = 0; i < 4; i++) begin
         pulse_step();
         check("R4 lower pass");
         check("R7 lower code");
      end
   endtask

   task automatic t_wrap();
      pulse_step();
      check("R5 wrap to start");
      for (int i = 0; i < 8; i++) pulse_step();
      check("R5 full loop");
   endtask

   task automatic t_burst();
      @(negedge clk) step = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         epos = (epos + 1) % 8;
         check("R8 held step");
      end
      step = 1'b0;
      @(negedge clk);
      check("R8 stop after burst");
      @(negedge clk) step = 1'b1;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         epos = (epos + 1) % 8;
         check("R8 long burst");
      end
      step = 1'b0;
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      t_reset();
      t_hold();
      t_upper();
      t_lower();
      t_wrap();
      t_burst();
      t_reset();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end
endmodule